// File: doc/BRIEF.md
# Multicycle Fetch-Decode-Execute Processor Core

This block is a small processor core that runs one instruction at a time through a fixed series of steps. A Moore control machine steps through fetch, decode and one or two execute states. A shared datapath holds the program counter, the instruction register, a file of eight 16-bit registers and a single ALU. The same ALU that does the arithmetic for instructions also adds one to the program counter during fetch. It also checks a register for zero when a conditional branch is tested.

The core has a single synchronous port for both instructions and data. It consists of an 8-bit address, a read strobe, a write strobe, write data and read data. Read data returns one clock after the read strobe. Each instruction is 16 bits wide. Bits 15:12 hold the opcode. The fields in bits 11:8, 7:4 and 3:0 name the destination register and the two source registers. The low 8 bits give the memory address or the branch target.

Top module: `cpu_core`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the core drives address 0 with the read strobe high and the write strobe low. The program counter restarts at 0.
- R2: In a fetch cycle the core drives the program counter on the address bus with the read strobe high. The word returned in the next cycle becomes the current instruction. After any non-branching instruction, the next fetch uses the following address, modulo 256.
- R3: Bits 15:12 of an instruction hold the opcode. Bits 11:8 name the destination register (rd), bits 7:4 name the first source (rs) and bits 3:0 name the second source (rt). Only the low 3 bits of a register field select one of the eight registers. Bits 7:0 hold the memory address or branch target.
- R4: The opcodes 0 to 4 mean add, subtract (rs minus rt), AND, OR and XOR. Each is computed modulo 2^16 and written to rd.
- R5: A register-to-register instruction fetched in cycle c is followed by the next fetch in cycle c+3.
- R6: Opcode 5 (load) reads memory at bits 7:0 in cycle c+2 and writes the returned word to rd. The next fetch comes in cycle c+4.
- R7: Opcode 6 (store) writes the register named by bits 11:8 to memory at bits 7:0. The write strobe is high only in cycle c+2, and the next fetch comes in cycle c+3.
- R8: Opcode 7 (branch if zero) tests the register named by bits 11:8. If that register is zero, the next fetch is from bits 7:0 in cycle c+4. If it is not zero, the next fetch is sequential in cycle c+3.
- R9: Opcode 8 (jump) makes the next fetch come from bits 7:0 in cycle c+3.
- R10: Opcodes 9 to 15 change no register and write no memory. The next fetch is sequential in cycle c+2.
- R11: If an ALU instruction names the same register as both destination and source, it reads the old value of that register and then writes the new one.
- R12: The read strobe and the write strobe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 8 | Memory address |
| memRead | output | 1 | Read strobe; data returns one cycle later |
| memWrite | output | 1 | Write strobe |
| memWdata | output | 16 | Store data |
| memRdata | input | 16 | Read data from memory |

## Verification
Cycle c is the fetch cycle of an instruction. Counting from c, the next fetch is due at c+3 for ALU ops, stores, jumps and untaken branches. It is due at c+4 for loads and taken branches, and at c+2 for undefined opcodes. The store strobe is due at c+2. The bench records the address and strobes in every cycle after reset is released, sampling at the falling edge. It then compares each recorded entry with the cycle number worked out from the program it loaded, so a cycle gained or lost anywhere in the sequence shows up as a mismatch. The stored value is checked both on the write bus in its own cycle and in bench memory afterwards.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 8;
  localparam int NREG    = 8;
  localparam int FIELD_W = 4;
  localparam int OPC_LSB = 12;
  localparam int RD_LSB  = 8;
  localparam int RS_LSB  = 4;
  localparam int RT_LSB  = 0;

  typedef enum logic [FIELD_W-1:0] {
    OPC_ADD = 4'd0, OPC_SUB = 4'd1, OPC_AND = 4'd2, OPC_OR = 4'd3,
    OPC_XOR = 4'd4, OPC_LOAD = 4'd5, OPC_STORE = 4'd6, OPC_BZ = 4'd7,
    OPC_JMP = 4'd8
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR
  } aluop_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXALU, ST_LDADDR, ST_LDWB, ST_STORE,
    ST_BRTEST, ST_BRTAKE
  } state_e;

  typedef enum logic [1:0] {
    BSEL_ONE, BSEL_REG, BSEL_ZERO
  } bsel_e;

  typedef struct packed {
    logic   memRead;
    logic   memWrite;
    logic   addrFromIr;
    logic   irLoad;
    logic   pcLoad;
    logic   pcFromIr;
    logic   aFromPc;
    bsel_e  bSel;
    logic   aPortRd;
    logic   regWrite;
    logic   wrFromMem;
    aluop_e aluOp;
  } ctrl_t;
endpackage

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  aluop_e       op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import cpu_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int N  = NREG,
  parameter int FW = FIELD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] raddrA,
  input  logic [FW-1:0] raddrB,
  input  logic [FW-1:0] waddr,
  input  logic          wen,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdataA,
  output logic [W-1:0]  rdataB
);
  logic [W-1:0] regs [N];

  assign rdataA = regs[int'(raddrA) % N];
  assign rdataB = regs[int'(raddrB) % N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs[i] <= '0;
      else if (wen && (int'(waddr) % N) == i) regs[i] <= wdata;
    end
  end
endmodule

// File: rtl/cpu_control.sv
module cpu_control
  import cpu_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [FIELD_W-1:0] fetchOp,
  input  logic [FIELD_W-1:0] irOp,
  input  logic               aluZero,
  output ctrl_t              ctl,
  output state_e             state
);
  state_e nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= nextState;
  end

  always_comb begin
    nextState = ST_FETCH;
    unique case (state)
      ST_FETCH:  nextState = ST_DECODE;
      ST_DECODE: begin
        case (opcode_e'(fetchOp))
          OPC_ADD, OPC_SUB, OPC_AND, OPC_OR, OPC_XOR: nextState = ST_EXALU;
          OPC_LOAD:  nextState = ST_LDADDR;
          OPC_STORE: nextState = ST_STORE;
          OPC_BZ:    nextState = ST_BRTEST;
          OPC_JMP:   nextState = ST_BRTAKE;
          default:   nextState = ST_FETCH;
        endcase
      end
      ST_LDADDR: nextState = ST_LDWB;
      ST_BRTEST: nextState = aluZero ? ST_BRTAKE : ST_FETCH;
      default:   nextState = ST_FETCH;
    endcase
  end

  aluop_e irAluOp;
  always_comb begin
    case (opcode_e'(irOp))
      OPC_SUB: irAluOp = ALU_SUB;
      OPC_AND: irAluOp = ALU_AND;
      OPC_OR:  irAluOp = ALU_OR;
      OPC_XOR: irAluOp = ALU_XOR;
      default: irAluOp = ALU_ADD;
    endcase
  end

  // Moore outputs: a function of the present state only (IR is a held register)
  always_comb begin
    ctl = '{bSel: BSEL_REG, aluOp: ALU_ADD, default: 1'b0};
    unique case (state)
      ST_FETCH: begin
        ctl.memRead = 1'b1;
        ctl.aFromPc = 1'b1;
        ctl.bSel    = BSEL_ONE;
        ctl.pcLoad  = 1'b1;
      end
      ST_DECODE: ctl.irLoad = 1'b1;
      ST_EXALU: begin
        ctl.regWrite = 1'b1;
        ctl.aluOp    = irAluOp;
      end
      ST_LDADDR: begin
        ctl.memRead    = 1'b1;
        ctl.addrFromIr = 1'b1;
      end
      ST_LDWB: begin
        ctl.regWrite  = 1'b1;
        ctl.wrFromMem = 1'b1;
      end
      ST_STORE: begin
        ctl.memWrite   = 1'b1;
        ctl.addrFromIr = 1'b1;
        ctl.aPortRd    = 1'b1;
      end
      ST_BRTEST: begin
        ctl.aPortRd = 1'b1;
        ctl.bSel    = BSEL_ZERO;
      end
      ST_BRTAKE: begin
        ctl.pcLoad   = 1'b1;
        ctl.pcFromIr = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cpu_datapath.sv
module cpu_datapath
  import cpu_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  ctrl_t              ctl,
  input  logic [DATA_W-1:0]  memRdata,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWdata,
  output logic [FIELD_W-1:0] irOp,
  output logic               aluZero,
  output logic [ADDR_W-1:0]  pcVal
);
  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] rdA, rdB, aluA, aluB, aluY, wrData;
  logic [FIELD_W-1:0] fieldRd, fieldRs, fieldRt;

  assign fieldRd = ir[RD_LSB +: FIELD_W];
  assign fieldRs = ir[RS_LSB +: FIELD_W];
  assign fieldRt = ir[RT_LSB +: FIELD_W];
  assign irOp    = ir[OPC_LSB +: FIELD_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      ir <= '0;
    end else begin
      if (ctl.irLoad) ir <= memRdata;
      if (ctl.pcLoad) pc <= ctl.pcFromIr ? ir[ADDR_W-1:0] : aluY[ADDR_W-1:0];
    end
  end

  cpu_regfile u_rf (
    .clk    (clk),
    .rst    (rst),
    .raddrA (ctl.aPortRd ? fieldRd : fieldRs),
    .raddrB (fieldRt),
    .waddr  (fieldRd),
    .wen    (ctl.regWrite),
    .wdata  (wrData),
    .rdataA (rdA),
    .rdataB (rdB)
  );

  assign aluA = ctl.aFromPc ? {{(DATA_W-ADDR_W){1'b0}}, pc} : rdA;
  always_comb begin
    unique case (ctl.bSel)
      BSEL_ONE:  aluB = DATA_W'(1);
      BSEL_ZERO: aluB = '0;
      default:   aluB = rdB;
    endcase
  end

  cpu_alu u_alu (
    .a    (aluA),
    .b    (aluB),
    .op   (ctl.aluOp),
    .y    (aluY),
    .zero (aluZero)
  );

  assign wrData   = ctl.wrFromMem ? memRdata : aluY;
  assign memAddr  = ctl.addrFromIr ? ir[ADDR_W-1:0] : pc;
  assign memWdata = rdA;
  assign pcVal    = pc;
endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRead,
  output logic              memWrite,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);
  ctrl_t              ctl;
  state_e             curState;
  logic [FIELD_W-1:0] irOp;
  logic               aluZero;
  logic [ADDR_W-1:0]  pcVal;

  cpu_control u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .fetchOp (memRdata[OPC_LSB +: FIELD_W]),
    .irOp    (irOp),
    .aluZero (aluZero),
    .ctl     (ctl),
    .state   (curState)
  );

  cpu_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .irOp     (irOp),
    .aluZero  (aluZero),
    .pcVal    (pcVal)
  );

  assign memRead  = ctl.memRead;
  assign memWrite = ctl.memWrite;
endmodule

// File: rtl/cpu_core_chk.sv
module cpu_core_chk
  import cpu_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRead,
  input logic              memWrite,
  input state_e            state,
  input logic [ADDR_W-1:0] pc
);
  p_rd_wr_exclusive_r12: assert property (@(posedge clk) disable iff (rst)
    !(memRead && memWrite));

  p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (memAddr == '0 && memRead && !memWrite));

  p_pc_increment_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> (ADDR_W'(pc - $past(pc)) == ADDR_W'(1)));

  p_decode_after_fetch_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE) |-> ($past(state) == ST_FETCH));

  p_store_third_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    memWrite |-> ($past(state) == ST_DECODE));

  p_store_then_fetch_r7: assert property (@(posedge clk) disable iff (rst)
    memWrite |=> (memRead && state == ST_FETCH));
endmodule

bind cpu_core cpu_core_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .memAddr  (memAddr),
  .memRead  (memRead),
  .memWrite (memWrite),
  .state    (curState),
  .pc       (pcVal)
);

// File: tb/tb_cpu_core.sv
module tb_cpu_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  memAddr;
  logic        memRead, memWrite;
  logic [15:0] memWdata;
  logic [15:0] memRdata;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  cpu_core dut (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memRead(memRead),
    .memWrite(memWrite), .memWdata(memWdata), .memRdata(memRdata)
  );

  logic [15:0] mem [256];
  always @(posedge clk) begin
    if (memWrite) mem[memAddr] <= memWdata;
    if (memRead)  memRdata <= mem[memAddr];
  end

  logic [7:0]  tAddr [32];
  logic        tRd   [32];
  logic        tWr   [32];
  logic [15:0] tWd   [32];

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sample(int i);
    tAddr[i] = memAddr; tRd[i] = memRead; tWr[i] = memWrite; tWd[i] = memWdata;
  endtask

  task automatic runCase(int n);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1 sample(0);
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      #1 sample(i);
    end
  endtask

  // expects a fetch (read strobe, address) in cycle i
  task automatic expectFetch(string req, int i, logic [7:0] addr);
    check(req, {7'd0, tRd[i], addr}, {7'd0, 1'b1, addr});
  endtask

  function automatic logic [15:0] refOp(int op, logic [15:0] a, logic [15:0] b);
    case (op)
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      default: return a + b;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  logic [15:0] vals [6] = '{16'h0000, 16'h0001, 16'h7fff, 16'h8000, 16'hffff, 16'h1234};

  initial begin
    // R1: reset state, jump R9
    mem[0] = 16'h8020;
    mem[8'h20] = 16'h8020;
    runCase(6);
    check("R1 addr", {8'd0, tAddr[0]}, 16'h0000);
    check("R1 rd", {15'd0, tRd[0]}, 16'h0001);
    check("R1 wr", {15'd0, tWr[0]}, 16'h0000);
    expectFetch("R9 jump target", 3, 8'h20);

    // ALU sweep: R2 R3 R4 R5 R6 R7 R11
    for (int op = 0; op < 5; op++)
      for (int ia = 0; ia < 6; ia++)
        for (int ib = 0; ib < 6; ib++)
          for (int v = 0; v < 2; v++) begin
            logic [15:0] exp;
            mem[0] = 16'h5180;                                   // LD r1,[80]
            mem[1] = 16'h5281;                                   // LD r2,[81]
            mem[2] = (v == 0) ? {op[3:0], 12'hB12} : {op[3:0], 12'h112};
            mem[3] = (v == 0) ? 16'h6390 : 16'h6190;             // ST rX,[90]
            mem[4] = 16'h8004;
            mem[8'h80] = vals[ia];
            mem[8'h81] = vals[ib];
            mem[8'h90] = 16'hdead;
            exp = refOp(op, vals[ia], vals[ib]);
            runCase(20);
            check("R6 load read cycle", {7'd0, tRd[2], tAddr[2]}, 16'h0180);
            expectFetch("R6 load length", 4, 8'h01);
            expectFetch("R2 sequential fetch", 8, 8'h02);
            expectFetch("R5 alu length", 11, 8'h03);
            check("R7 no early write", {15'd0, tWr[12]}, 16'h0000);
            check("R7 write cycle", {7'd0, tWr[13], tAddr[13]}, 16'h0190);
            check((v == 0) ? "R4 R3 result" : "R11 same reg", tWd[13], exp);
            expectFetch("R7 store length", 14, 8'h04);
            check("R4 mem", mem[8'h90], exp);
          end

    // R8 branch if zero
    for (int ia = 0; ia < 6; ia++) begin
      mem[0] = 16'h5180;
      mem[1] = 16'h7110;
      mem[2] = 16'h8002;
      mem[8'h10] = 16'h8010;
      mem[8'h80] = vals[ia];
      runCase(12);
      if (vals[ia] == 16'h0) expectFetch("R8 taken", 8, 8'h10);
      else                   expectFetch("R8 not taken", 7, 8'h02);
    end

    // R10 undefined opcodes
    for (int op = 9; op < 16; op++) begin
      mem[0] = 16'h5180;
      mem[1] = {op[3:0], 12'h111};
      mem[2] = 16'h6190;
      mem[3] = 16'h8003;
      mem[8'h80] = 16'ha5c3;
      mem[8'h90] = 16'h0000;
      runCase(14);
      expectFetch("R10 length", 6, 8'h02);
      for (int i = 4; i < 8; i++) check("R10 no write", {15'd0, tWr[i]}, 16'h0000);
      check("R10 reg kept", tWd[8], 16'ha5c3);
      check("R10 mem", mem[8'h90], 16'ha5c3);
    end

    // R12 strobes exclusive (over last trace)
    for (int i = 0; i < 14; i++) check("R12 strobes", {15'd0, tRd[i] & tWr[i]}, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule